// File: doc/BRIEF.md
# Table-Driven AGC Loop Controller

This block closes an automatic gain control loop around an external step-gain amplifier. It takes the signed ADC samples that follow the amplifier and measures their level with an envelope detector. The detector takes the magnitude of each sample and smooths it with a two-stage CIC lowpass that decimates by 8. Each decimated level is turned into a 5-bit logarithmic index. The index selects a signed 8-bit error from a 32-entry table that the host writes. The table contents set the reference level, the dead zone and the slope of the loop response.

The selected error is shifted left by a programmable loop-gain amount and added to a saturating 16-bit integrator. The top three bits of the integrator form the gain code for the amplifier. The integrator value is also brought out as a port, so the final loop state can be read back.

A small state machine decides when the loop is closed. The states are `ST_OPEN` (loop open, integrator frozen), `ST_RUN` (loop closed) and `ST_COUNT` (loop closed for a counted burst). It has these transitions:
- `ST_OPEN`→`ST_RUN` in free-run mode, or in gate-level mode while the gate is high.
- `ST_OPEN`→`ST_COUNT` on a rising gate edge in edge mode.
- `ST_RUN`→`ST_OPEN` when the run condition drops.
- `ST_COUNT`→`ST_OPEN` when the burst counter reaches its terminal value or the mode leaves edge mode.
- `ST_COUNT`→`ST_RUN` when the mode is changed to free-run.

Separate controls preload and hold the integrator, and force the output code.

Top module: `agc_loop_ctrl`

## Requirements
- R1: While reset is asserted, `integ_q` is 0, `gain_code` is 0 and `loop_active` is 0.
- R2: The detector output is the magnitude of the signed sample (two's complement; -x maps to x), filtered by a two-stage CIC. The CIC output is 64 times the mean magnitude. One detector output, and at most one integrator update, is produced for every 8 valid samples.
- R3: For an 18-bit detector value D, let p be the position of its highest set bit and b the bit just below it (b is 0 when p is 0). The table index is 2p+b-4, clamped to the range 0..31. When D is 0 the index is 0.
- R4: A write with `tbl_we` stores the signed 8-bit `tbl_wdata` in entry `tbl_addr`. The loop error for a detector output is the entry at that output's index. All entries are 0 after reset.
- R5: Each integrator update adds the error multiplied by 2^`loop_shift`.
- R6: The integrator saturates at 0 and at 65535 and never wraps.
- R7: `gain_code` equals bits 15:13 of `integ_q` unless the output is forced.
- R8: With `cfg_mode`=00 (free-run), the loop is closed at every cycle after the first cycle following reset.
- R9: With `cfg_mode`=01 (gate-level), the loop is closed only while `gate_in` is high. While it is open, the integrator does not change.
- R10: With `cfg_mode`=10 (gate-edge), a rising edge of `gate_in` closes the loop for exactly `cfg_term`+1 cycles. Holding the gate high afterwards does not reopen it. `cfg_mode`=11 keeps the loop open.
- R11: While `ic_hold` is high, the integrator holds {`ic_code`, 13'b0} and loop updates are ignored.
- R12: While `force_en` is high, `gain_code` equals `force_code`, and `integ_q` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | ADC sample strobe |
| smp_data | input | 12 | Signed ADC sample |
| tbl_we | input | 1 | Error table write enable |
| tbl_addr | input | 5 | Error table entry address |
| tbl_wdata | input | 8 | Signed error value to store |
| cfg_mode | input | 2 | 00 free-run, 01 gate-level, 10 gate-edge, 11 open |
| cfg_term | input | 12 | Burst terminal count for gate-edge mode |
| gate_in | input | 1 | Gate signal |
| loop_shift | input | 4 | Loop gain as a left shift of the error |
| ic_hold | input | 1 | Load and hold the initial condition |
| ic_code | input | 3 | Initial gain code |
| force_en | input | 1 | Override the gain code |
| force_code | input | 3 | Forced gain code |
| gain_code | output | 3 | Gain code to the amplifier |
| integ_q | output | 16 | Integrator readback |
| loop_active | output | 1 | Loop is closed |

## Verification
The bench keeps its own model of the CIC step response and the logarithmic index, and predicts the integrator after each burst of samples.

Step changes in level between bursts exercise the partial first decimated output. A wrong comb or integrator order would shift the index and add the wrong table entry.

A three-region table checks the dead zone. There the integrator must not move, while levels below and above the band push it in opposite directions.

Saturation is checked at both ends with the largest shift. A wrapping adder would jump from code 7 to 0 or from 0 to 7.

The burst length in edge mode is counted cycle by cycle against `cfg_term`+1, which catches an off-by-one counter or a level-triggered retrigger. Hold and force are checked to stop, respectively pass, the integrator.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_RUN   = 2'd1,
        ST_COUNT = 2'd2
    } agc_state_e;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_GATE = 2'd1,
        MODE_EDGE = 2'd2,
        MODE_OFF  = 2'd3
    } agc_mode_e;
endpackage

// File: rtl/agc_env_det.sv
module agc_env_det #(
    parameter int SMP_W = 12,
    parameter int DEC   = 8,
    localparam int DET_W = SMP_W + 2 * $clog2(DEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             det_vld,
    output logic [DET_W-1:0] det_mag
);
    localparam int PH_W = $clog2(DEC);

    logic [SMP_W-1:0] mag;
    logic [DET_W-1:0] int1_q, int2_q, int1_nxt, int2_nxt;
    logic [DET_W-1:0] dly1_q, dly2_q, comb1, comb2;
    logic [PH_W-1:0]  phase_q;
    logic             dec_tick;

    always_comb begin
        mag      = smp_data[SMP_W-1] ? (~smp_data + 1'b1) : smp_data;
        int1_nxt = int1_q + DET_W'(mag);
        int2_nxt = int2_q + int1_nxt;
        comb1    = int2_nxt - dly1_q;
        comb2    = comb1 - dly2_q;
        dec_tick = smp_valid && (phase_q == PH_W'(DEC - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int1_q  <= '0;
            int2_q  <= '0;
            dly1_q  <= '0;
            dly2_q  <= '0;
            phase_q <= '0;
            det_vld <= 1'b0;
            det_mag <= '0;
        end else begin
            det_vld <= 1'b0;
            if (smp_valid) begin
                int1_q  <= int1_nxt;
                int2_q  <= int2_nxt;
                phase_q <= phase_q + 1'b1;
            end
            if (dec_tick) begin
                dly1_q  <= int2_nxt;
                dly2_q  <= comb1;
                det_mag <= comb2;
                det_vld <= 1'b1;
            end
        end
    end

    // R2
    single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_vld |=> !det_vld);
endmodule

// File: rtl/agc_err_lut.sv
module agc_err_lut #(
    parameter int DET_W   = 18,
    parameter int ERR_W   = 8,
    parameter int DEPTH   = 32,
    parameter int IDX_OFS = 4,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DET_W-1:0]        det_mag,
    input  logic                    tbl_we,
    input  logic [IDX_W-1:0]        tbl_addr,
    input  logic [ERR_W-1:0]        tbl_wdata,
    output logic signed [ERR_W-1:0] err
);
    logic [ERR_W-1:0] tbl_q [DEPTH];
    logic [IDX_W-1:0] idx;
    int lead;
    int mant;
    int raw;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_q[g] <= '0;
            else if (tbl_we && tbl_addr == IDX_W'(g))
                tbl_q[g] <= tbl_wdata;
        end
    end

    always_comb begin
        lead = 0;
        for (int i = 0; i < DET_W; i++)
            if (det_mag[i]) lead = i;
        mant = (lead > 0) ? int'(det_mag[lead-1]) : 0;
        raw  = 2 * lead + mant - IDX_OFS;
        if (raw < 0)
            idx = '0;
        else if (raw > DEPTH - 1)
            idx = IDX_W'(DEPTH - 1);
        else
            idx = IDX_W'(raw);
        err = $signed(tbl_q[idx]);
    end
endmodule

// File: rtl/agc_gate_fsm.sv
module agc_gate_fsm
    import agc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_term,
    input  logic             gate_in,
    output logic             loop_active
);
    agc_state_e state_q, state_nxt;
    agc_mode_e  mode;
    logic [CNT_W-1:0] cnt_q;
    logic gate_d_q, gate_rise, run_ok;

    always_comb begin
        mode      = agc_mode_e'(cfg_mode);
        gate_rise = gate_in && !gate_d_q;
        run_ok    = (mode == MODE_FREE) || (mode == MODE_GATE && gate_in);
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (run_ok)
                    state_nxt = ST_RUN;
                else if (mode == MODE_EDGE && gate_rise)
                    state_nxt = ST_COUNT;
            end
            ST_RUN: begin
                if (!run_ok)
                    state_nxt = ST_OPEN;
            end
            ST_COUNT: begin
                if (mode == MODE_FREE)
                    state_nxt = ST_RUN;
                else if (mode != MODE_EDGE || cnt_q == cfg_term)
                    state_nxt = ST_OPEN;
            end
            default: state_nxt = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_OPEN;
            cnt_q    <= '0;
            gate_d_q <= 1'b0;
        end else begin
            state_q  <= state_nxt;
            gate_d_q <= gate_in;
            cnt_q    <= (state_q == ST_COUNT) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        loop_active = (state_q == ST_RUN) || (state_q == ST_COUNT);
    end

    // R8
    free_run_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0) |=> loop_active);

    // R10
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && cfg_mode == 2'd2 && cnt_q == cfg_term) |=> !loop_active);
endmodule

// File: rtl/agc_integ.sv
module agc_integ #(
    parameter int ERR_W  = 8,
    parameter int INT_W  = 16,
    parameter int SH_W   = 4,
    parameter int GAIN_W = 3,
    localparam int EXT_W = INT_W + ERR_W + (1 << SH_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic                    active,
    input  logic                    hold,
    input  logic [GAIN_W-1:0]       ic_code,
    input  logic signed [ERR_W-1:0] err,
    input  logic [SH_W-1:0]         shift,
    output logic [INT_W-1:0]        integ_q
);
    localparam logic signed [EXT_W-1:0] MAXV = EXT_W'({INT_W{1'b1}});

    logic signed [EXT_W-1:0] err_ext, sum;
    logic [INT_W-1:0] sat_val;

    always_comb begin
        err_ext = EXT_W'(err) <<< shift;
        sum     = $signed({{(EXT_W-INT_W){1'b0}}, integ_q}) + err_ext;
        if (sum < 0)
            sat_val = '0;
        else if (sum > MAXV)
            sat_val = '1;
        else
            sat_val = sum[INT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            integ_q <= '0;
        else if (hold)
            integ_q <= {ic_code, {(INT_W-GAIN_W){1'b0}}};
        else if (upd && active)
            integ_q <= sat_val;
    end

    // R11
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> integ_q == {$past(ic_code), {(INT_W-GAIN_W){1'b0}}});

    // R6
    no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && active && !hold && err >= 0) |=> integ_q >= $past(integ_q));

    // R6
    no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && active && !hold && err <= 0) |=> integ_q <= $past(integ_q));

    // R9
    frozen_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !hold) |=> $stable(integ_q));
endmodule

// File: rtl/agc_loop_ctrl.sv
module agc_loop_ctrl #(
    parameter int SMP_W   = 12,
    parameter int DEC     = 8,
    parameter int ERR_W   = 8,
    parameter int DEPTH   = 32,
    parameter int IDX_OFS = 4,
    parameter int INT_W   = 16,
    parameter int SH_W    = 4,
    parameter int GAIN_W  = 3,
    parameter int CNT_W   = 12,
    localparam int DET_W  = SMP_W + 2 * $clog2(DEC),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic [ERR_W-1:0]  tbl_wdata,
    input  logic [1:0]        cfg_mode,
    input  logic [CNT_W-1:0]  cfg_term,
    input  logic              gate_in,
    input  logic [SH_W-1:0]   loop_shift,
    input  logic              ic_hold,
    input  logic [GAIN_W-1:0] ic_code,
    input  logic              force_en,
    input  logic [GAIN_W-1:0] force_code,
    output logic [GAIN_W-1:0] gain_code,
    output logic [INT_W-1:0]  integ_q,
    output logic              loop_active
);
    logic                    det_vld;
    logic [DET_W-1:0]        det_mag;
    logic signed [ERR_W-1:0] err;

    agc_env_det #(.SMP_W(SMP_W), .DEC(DEC)) u_det (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .det_vld(det_vld), .det_mag(det_mag)
    );

    agc_err_lut #(.DET_W(DET_W), .ERR_W(ERR_W), .DEPTH(DEPTH), .IDX_OFS(IDX_OFS)) u_lut (
        .clk(clk), .rst_n(rst_n), .det_mag(det_mag), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .err(err)
    );

    agc_gate_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_term(cfg_term),
        .gate_in(gate_in), .loop_active(loop_active)
    );

    agc_integ #(.ERR_W(ERR_W), .INT_W(INT_W), .SH_W(SH_W), .GAIN_W(GAIN_W)) u_int (
        .clk(clk), .rst_n(rst_n), .upd(det_vld), .active(loop_active),
        .hold(ic_hold), .ic_code(ic_code), .err(err), .shift(loop_shift),
        .integ_q(integ_q)
    );

    always_comb begin
        gain_code = force_en ? force_code : integ_q[INT_W-1 -: GAIN_W];
    end

    // R12
    force_keeps_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_en && !loop_active && !ic_hold) |=> $stable(integ_q));
endmodule

// File: tb/agc_loop_ctrl_test.sv
`timescale 1ns/1ps
module agc_loop_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_addr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [11:0] cfg_term = '0;
    logic        gate_in = 1'b0;
    logic [3:0]  loop_shift = '0;
    logic        ic_hold = 1'b0;
    logic [2:0]  ic_code = '0;
    logic        force_en = 1'b0;
    logic [2:0]  force_code = '0;
    logic [2:0]  gain_code;
    logic [15:0] integ_q;
    logic        loop_active;

    int checks = 0;
    int fails = 0;
    int tbl_m [32];
    int exp_int = 0;
    int prev_mag = 0;
    bit act_m = 1'b1;

    always #4 clk = ~clk;

    agc_loop_ctrl uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .cfg_mode(cfg_mode), .cfg_term(cfg_term), .gate_in(gate_in),
        .loop_shift(loop_shift), .ic_hold(ic_hold), .ic_code(ic_code),
        .force_en(force_en), .force_code(force_code), .gain_code(gain_code),
        .integ_q(integ_q), .loop_active(loop_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int idx_of(input int d);
        int p = 0;
        int b = 0;
        int r;
        if (d <= 0) return 0;
        for (int i = 0; i < 18; i++) if ((d >> i) & 1) p = i;
        if (p > 0) b = (d >> (p - 1)) & 1;
        r = 2 * p + b - 4;
        if (r < 0) r = 0;
        if (r > 31) r = 31;
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) tbl_m[i] = 0;
        exp_int = 0;
        prev_mag = 0;
        @(negedge clk);
    endtask

    task automatic load_tbl(input int lo_v, input int mid_v, input int hi_v,
                            input int lo_end, input int hi_start);
        for (int i = 0; i < 32; i++) begin
            int v = (i < lo_end) ? lo_v : ((i >= hi_start) ? hi_v : mid_v);
            tbl_m[i] = v;
            tbl_we = 1'b1;
            tbl_addr = 5'(i);
            tbl_wdata = 8'(v);
            @(negedge clk);
        end
        tbl_we = 1'b0;
    endtask

    // drive n (multiple of 8) samples of value s and predict the integrator
    task automatic feed(input int s, input int n, input string req);
        int m = (s < 0) ? -s : s;
        for (int k = 1; k <= n / 8; k++) begin
            int d = 64 * prev_mag + (m - prev_mag) * ((k == 1) ? 36 : 64);
            if (act_m) begin
                exp_int = exp_int + tbl_m[idx_of(d)] * (1 << loop_shift);
                if (exp_int < 0) exp_int = 0;
                if (exp_int > 65535) exp_int = 65535;
            end
        end
        prev_mag = m;
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1;
            smp_data = 12'(s);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(req, int'(integ_q), exp_int);
        if (!force_en) chk("R7", int'(gain_code), exp_int >> 13);
    endtask

    task automatic set_ic(input int code);
        ic_code = 3'(code);
        ic_hold = 1'b1;
        repeat (2) @(negedge clk);
        ic_hold = 1'b0;
        exp_int = code << 13;
        chk("R11 load", int'(integ_q), exp_int);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 integ", int'(integ_q), 0);
        chk("R1 gain", int'(gain_code), 0);
        chk("R1 open", int'(loop_active), 0);
        do_reset();
        chk("R8 closed", int'(loop_active), 1);
    endtask

    task automatic t_step_shift();
        do_reset();
        act_m = 1'b1;
        load_tbl(1, 1, 1, 0, 32);
        loop_shift = 4'd0;
        feed(100, 80, "R2 R4 count");
        chk("R2 ten updates", int'(integ_q), 10);
        loop_shift = 4'd3;
        feed(100, 80, "R5 shift");
        feed(-100, 80, "R2 negative");
    endtask

    task automatic t_index();
        do_reset();
        act_m = 1'b1;
        loop_shift = 4'd0;
        load_tbl(0, 1, 0, 20, 22);
        feed(100, 80, "R3 band 20-21");
        feed(1000, 80, "R3 high idx");
        feed(1, 80, "R3 low idx");
    endtask

    task automatic t_saturate();
        do_reset();
        act_m = 1'b1;
        load_tbl(127, 127, 127, 0, 32);
        loop_shift = 4'd15;
        feed(50, 16, "R6 top");
        chk("R6 top value", int'(integ_q), 65535);
        feed(50, 32, "R6 no wrap up");
        set_ic(5);
        load_tbl(-128, -128, -128, 0, 32);
        feed(50, 32, "R6 bottom");
        chk("R6 bottom value", int'(integ_q), 0);
        feed(50, 32, "R6 no wrap down");
    endtask

    task automatic t_deadband();
        do_reset();
        act_m = 1'b1;
        loop_shift = 4'd0;
        load_tbl(8, 0, -8, 16, 25);
        set_ic(4);
        feed(100, 80, "R4 inside band");
        chk("R4 band no change", int'(integ_q), 16'h8000);
        feed(2, 80, "R4 below band");
        feed(1000, 80, "R4 above band");
    endtask

    task automatic t_hold();
        do_reset();
        act_m = 1'b0;
        load_tbl(5, 5, 5, 0, 32);
        ic_code = 3'd3;
        ic_hold = 1'b1;
        exp_int = 3 << 13;
        feed(200, 80, "R11 hold ignores loop");
        ic_hold = 1'b0;
        act_m = 1'b1;
        feed(200, 80, "R11 release");
    endtask

    task automatic t_force();
        do_reset();
        act_m = 1'b1;
        load_tbl(2, 2, 2, 0, 32);
        force_en = 1'b1;
        force_code = 3'd6;
        @(negedge clk);
        chk("R12 forced", int'(gain_code), 6);
        feed(300, 80, "R12 integ runs");
        chk("R12 still forced", int'(gain_code), 6);
        force_en = 1'b0;
        @(negedge clk);
        chk("R12 release", int'(gain_code), exp_int >> 13);
    endtask

    task automatic t_gate_level();
        do_reset();
        cfg_mode = 2'd1;
        gate_in = 1'b0;
        load_tbl(3, 3, 3, 0, 32);
        repeat (2) @(negedge clk);
        chk("R9 open", int'(loop_active), 0);
        act_m = 1'b0;
        feed(100, 80, "R9 frozen");
        gate_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 closed", int'(loop_active), 1);
        act_m = 1'b1;
        feed(100, 80, "R9 running");
        gate_in = 1'b0;
        repeat (2) @(negedge clk);
        act_m = 1'b0;
        feed(100, 80, "R9 frozen again");
        cfg_mode = 2'd0;
        act_m = 1'b1;
    endtask

    task automatic t_gate_edge();
        int n_act = 0;
        do_reset();
        cfg_mode = 2'd2;
        cfg_term = 12'd40;
        gate_in = 1'b0;
        load_tbl(3, 3, 3, 0, 32);
        repeat (3) @(negedge clk);
        chk("R10 idle open", int'(loop_active), 0);
        gate_in = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (loop_active) n_act++;
        end
        chk("R10 burst length", n_act, 41);
        act_m = 1'b0;
        feed(100, 80, "R10 level ignored");
        cfg_mode = 2'd3;
        gate_in = 1'b0;
        repeat (2) @(negedge clk);
        gate_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 mode 11 open", int'(loop_active), 0);
        cfg_mode = 2'd0;
        gate_in = 1'b0;
        act_m = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_step_shift();
        t_index();
        t_saturate();
        t_deadband();
        t_hold();
        t_force();
        t_gate_level();
        t_gate_edge();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule